// File: doc/BRIEF.md
# Prioritized Round-Robin Command Queue

This block sits between several buffered memory requesters and the pins that drive a DDR2 device's command bus. Each requester offers one command at a time: an address, a command kind and a priority. The requester's index serves as its source ID. A round-robin arbiter admits at most one command per cycle into an ordered queue of `DEPTH` entries. While the downstream scheduler holds `issue_en` high, the queue releases one command per cycle. It always picks the most urgent entry that is pending.

The released command becomes a registered DDR2 command word of chip select, row strobe, column strobe and write enable, together with its address and source ID. When no command goes out, the pins show deselect. Timing between DRAM commands is enforced upstream, through `issue_en`. The data paths that run beside the commands are outside this block.

Top module: `prio_cmd_queue`

## Requirements
- R1: During and right after reset the queue is empty, all four command pins are high (deselect), `issue_valid` is low, and the arbiter starts its search at requester 0.
- R2: At most one `req_ready` bit is high in a cycle. The search starts at the requester just after the one granted last, wraps around, and skips requesters whose `req_valid` is low. A lone valid requester on an empty queue is granted in the same cycle.
- R3: A `req_ready` bit is high only while that requester's `req_valid` is high. While the queue holds `DEPTH` entries, every `req_ready` bit is low. The first cycle after an entry has been issued, a waiting requester is granted again.
- R4: Of the pending entries, the one with the numerically larger priority issues first.
- R5: Among entries of equal priority, the entry with the lower source ID (requester index) issues first.
- R6: Entries with equal priority and equal source ID issue in the order they were accepted.
- R7: The command word {cs_n, ras_n, cas_n, we_n} is set by the 3-bit kind. 1 (activate) gives 0011, 2 (read) gives 0101, 3 (write) gives 0100, 4 (precharge) gives 0010, 5 (refresh) gives 0001. 0 and every other code give 0111 (no-op). The address and source ID travel with the command.
- R8: When `issue_en` was low, or the queue was empty, at the previous rising edge, the pins show deselect (1111) and `issue_valid` is low. At most one entry leaves per cycle. Output changes one edge after the pop.
- R9: Every accepted command issues exactly once. The occupancy changes by the number pushed minus the number issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_REQ | Per-requester command offered |
| req_ready | output | N_REQ | Per-requester grant; the command is taken at the edge |
| req_addr | input | N_REQ*ADDR_W | Packed addresses, requester i at bits i*ADDR_W |
| req_kind | input | N_REQ*3 | Packed command kinds (codes in R7) |
| req_prio | input | N_REQ*PRIO_W | Packed priorities, larger is more urgent |
| issue_en | input | 1 | Scheduler permits one command to leave this cycle |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ADDR_W | Address of the issued command |
| issue_src | output | SRC_W | Source ID of the issued command |
| issue_valid | output | 1 | Pins carry a command this cycle |

## Verification
The assertions assume that requesters follow a valid/ready handshake. They also assume that `rst` is held for at least two edges, so that the occupancy history is defined before checking begins. They do not assume that `issue_en` stays low while the queue is empty. The design must ignore it in that case, and the bench drives it high on an empty queue on purpose. The stimulus changes inputs only on falling edges. It holds each command's fields steady until the grant, and it releases the valid bit on the falling edge after acceptance. It never lets more than `DEPTH` commands be outstanding without issuing one.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_NOP   = 3'd0,
    K_ACT   = 3'd1,
    K_READ  = 3'd2,
    K_WRITE = 3'd3,
    K_PRE   = 3'd4,
    K_REF   = 3'd5
  } cmd_kind_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_DESEL = 4'b1111;

  function automatic logic [3:0] kind_to_pins(input logic [KIND_W-1:0] k);
    logic [3:0] p;
    case (k)
      K_ACT:   p = 4'b0011;
      K_READ:  p = 4'b0101;
      K_WRITE: p = 4'b0100;
      K_PRE:   p = 4'b0010;
      K_REF:   p = 4'b0001;
      default: p = 4'b0111;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/cmdq_rr_arb.sv
module cmdq_rr_arb #(
  parameter int N_REQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant
);
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam logic [IDX_W:0] N_EXT = (IDX_W+1)'(N_REQ);

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] gidx;
  logic             found;

  always_comb begin
    logic [IDX_W:0] cand;
    grant = '0;
    found = 1'b0;
    gidx  = '0;
    for (int k = 0; k < N_REQ; k++) begin
      cand = {1'b0, ptr} + (IDX_W+1)'(k);
      if (cand >= N_EXT) cand = cand - N_EXT;
      if (en && !found && req[cand[IDX_W-1:0]]) begin
        found = 1'b1;
        gidx  = cand[IDX_W-1:0];
      end
    end
    if (found) grant[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (found) begin
      if ({1'b0, gidx} + 1'b1 >= N_EXT) ptr <= '0;
      else ptr <= gidx + 1'b1;
    end
  end
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int ADDR_W = 16,
  parameter int PRIO_W = 2,
  parameter int SRC_W  = 2,
  parameter int KIND_W = 3,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [KIND_W-1:0] push_kind,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic [SRC_W-1:0]  push_src,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [KIND_W-1:0] head_kind,
  output logic [SRC_W-1:0]  head_src,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [KIND_W-1:0] e_kind [DEPTH];
  logic [PRIO_W-1:0] e_prio [DEPTH];
  logic [SRC_W-1:0]  e_src  [DEPTH];

  logic [IDX_W-1:0] sel;
  logic [CNT_W-1:0] wr_pos;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  // Slot 0 is the oldest entry; only a strictly better entry displaces the pick
  always_comb begin
    sel = '0;
    for (int i = 1; i < DEPTH; i++) begin
      if (CNT_W'(i) < count) begin
        if ((e_prio[i] > e_prio[sel]) ||
            ((e_prio[i] == e_prio[sel]) && (e_src[i] < e_src[sel])))
          sel = IDX_W'(i);
      end
    end
  end

  assign head_addr = e_addr[sel];
  assign head_kind = e_kind[sel];
  assign head_src  = e_src[sel];
  assign wr_pos    = count - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= sel) begin
          e_addr[i] <= e_addr[i+1];
          e_kind[i] <= e_kind[i+1];
          e_prio[i] <= e_prio[i+1];
          e_src[i]  <= e_src[i+1];
        end
      end
    end
    if (push) begin
      e_addr[wr_pos[IDX_W-1:0]] <= push_addr;
      e_kind[wr_pos[IDX_W-1:0]] <= push_kind;
      e_prio[wr_pos[IDX_W-1:0]] <= push_prio;
      e_src[wr_pos[IDX_W-1:0]]  <= push_src;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + CNT_W'(push) - CNT_W'(pop);
  end
endmodule

// File: rtl/cmdq_pin_enc.sv
module cmdq_pin_enc #(
  parameter int ADDR_W = 16,
  parameter int SRC_W  = 2,
  parameter int KIND_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [KIND_W-1:0] kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  src,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              valid_o
);
  import cmdq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= PINS_DESEL;
      addr_o  <= '0;
      src_o   <= '0;
      valid_o <= 1'b0;
    end else if (fire) begin
      {cs_n, ras_n, cas_n, we_n} <= kind_to_pins(kind);
      addr_o  <= addr;
      src_o   <= src;
      valid_o <= 1'b1;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= PINS_DESEL;
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_cmd_queue.sv
module prio_cmd_queue #(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 16,
  parameter int PRIO_W = 2,
  parameter int DEPTH  = 8,
  localparam int SRC_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int KIND_W = cmdq_pkg::KIND_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_REQ-1:0]        req_valid,
  output logic [N_REQ-1:0]        req_ready,
  input  logic [N_REQ*ADDR_W-1:0] req_addr,
  input  logic [N_REQ*KIND_W-1:0] req_kind,
  input  logic [N_REQ*PRIO_W-1:0] req_prio,
  input  logic                    issue_en,
  output logic                    dram_cs_n,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic [ADDR_W-1:0]       dram_addr,
  output logic [SRC_W-1:0]        issue_src,
  output logic                    issue_valid
);
  logic [N_REQ-1:0]  grant;
  logic              push, pop, q_empty, q_full;
  logic [CNT_W-1:0]  q_count;
  logic [ADDR_W-1:0] push_addr, head_addr;
  logic [KIND_W-1:0] push_kind, head_kind;
  logic [PRIO_W-1:0] push_prio;
  logic [SRC_W-1:0]  push_src, head_src;

  cmdq_rr_arb #(.N_REQ(N_REQ)) u_arb (
    .clk(clk), .rst(rst), .en(!q_full), .req(req_valid), .grant(grant)
  );

  assign req_ready = grant;
  assign push      = |grant;
  assign pop       = issue_en && !q_empty;

  always_comb begin
    push_addr = '0;
    push_kind = '0;
    push_prio = '0;
    push_src  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (grant[i]) begin
        push_addr = req_addr[i*ADDR_W +: ADDR_W];
        push_kind = req_kind[i*KIND_W +: KIND_W];
        push_prio = req_prio[i*PRIO_W +: PRIO_W];
        push_src  = SRC_W'(i);
      end
    end
  end

  cmdq_store #(
    .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .SRC_W(SRC_W), .KIND_W(KIND_W), .DEPTH(DEPTH)
  ) u_store (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(push_addr), .push_kind(push_kind),
    .push_prio(push_prio), .push_src(push_src),
    .pop(pop),
    .head_addr(head_addr), .head_kind(head_kind), .head_src(head_src),
    .count(q_count), .empty(q_empty), .full(q_full)
  );

  cmdq_pin_enc #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .KIND_W(KIND_W)) u_enc (
    .clk(clk), .rst(rst), .fire(pop),
    .kind(head_kind), .addr(head_addr), .src(head_src),
    .cs_n(dram_cs_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .addr_o(dram_addr), .src_o(issue_src), .valid_o(issue_valid)
  );
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
  parameter int N_REQ = 4,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] req_valid,
  input logic [N_REQ-1:0] req_ready,
  input logic             issue_en,
  input logic             dram_cs_n,
  input logic             issue_valid,
  input logic             push,
  input logic [CNT_W-1:0] q_count
);
  a_r2_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  a_r3_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (q_count == CNT_W'(DEPTH)) |-> (req_ready == '0));

  a_r8_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    !issue_en |=> (dram_cs_n && !issue_valid));

  a_r8_issue_needs_entry: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> ($past(q_count) != '0));

  a_r9_count_track: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, q_count} == {1'b0, $past(q_count)} + (CNT_W+1)'($past(push))
                        - (CNT_W+1)'(issue_valid)));
endmodule

bind prio_cmd_queue cmdq_checker #(.N_REQ(N_REQ), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .issue_en(issue_en), .dram_cs_n(dram_cs_n), .issue_valid(issue_valid),
  .push(push), .q_count(q_count)
);

// File: tb/test_prio_cmd_queue.sv
`timescale 1ns/1ps
module test_prio_cmd_queue;
  localparam int N = 4, AW = 16, PW = 2, D = 8, SW = 2, KW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*KW-1:0] req_kind = '0;
  logic [N*PW-1:0] req_prio = '0;
  logic issue_en = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, issue_valid;
  logic [AW-1:0] dram_addr;
  logic [SW-1:0] issue_src;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] m_addr [32];
  logic [KW-1:0] m_kind [32];
  logic [PW-1:0] m_prio [32];
  logic [SW-1:0] m_src  [32];
  int m_n = 0;

  always #2.5 clk = ~clk;

  prio_cmd_queue #(.N_REQ(N), .ADDR_W(AW), .PRIO_W(PW), .DEPTH(D)) i_prio_cmd_queue (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_prio(req_prio),
    .issue_en(issue_en), .dram_cs_n(cs_n), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(dram_addr),
    .issue_src(issue_src), .issue_valid(issue_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // R7 table, written from the requirement
  function automatic logic [3:0] exp_pins(input logic [KW-1:0] k);
    case (k)
      3'd1: return 4'b0011;
      3'd2: return 4'b0101;
      3'd3: return 4'b0100;
      3'd4: return 4'b0010;
      3'd5: return 4'b0001;
      default: return 4'b0111;
    endcase
  endfunction

  task automatic m_add(input int s, input logic [KW-1:0] k, input logic [PW-1:0] p, input logic [AW-1:0] a);
    m_src[m_n] = SW'(s); m_kind[m_n] = k; m_prio[m_n] = p; m_addr[m_n] = a;
    m_n++;
  endtask

  // R4/R5/R6 ordering model: take best, oldest wins ties
  task automatic m_take(output logic [SW-1:0] s, output logic [KW-1:0] k, output logic [AW-1:0] a);
    int b = 0;
    for (int i = 1; i < m_n; i++)
      if (m_prio[i] > m_prio[b] || (m_prio[i] == m_prio[b] && m_src[i] < m_src[b])) b = i;
    s = m_src[b]; k = m_kind[b]; a = m_addr[b];
    for (int i = b; i < m_n - 1; i++) begin
      m_src[i] = m_src[i+1]; m_kind[i] = m_kind[i+1];
      m_prio[i] = m_prio[i+1]; m_addr[i] = m_addr[i+1];
    end
    m_n--;
  endtask

  task automatic set_req(input int s, input logic [KW-1:0] k, input logic [PW-1:0] p, input logic [AW-1:0] a);
    req_kind[s*KW +: KW] = k;
    req_prio[s*PW +: PW] = p;
    req_addr[s*AW +: AW] = a;
  endtask

  task automatic push_one(input int s, input logic [KW-1:0] k, input logic [PW-1:0] p, input logic [AW-1:0] a);
    @(negedge clk);
    set_req(s, k, p, a);
    req_valid[s] = 1'b1;
    #1;
    chk(req_ready == (N'(1) << s), "R2 lone requester granted", req_ready, N'(1) << s);
    m_add(s, k, p, a);
    @(negedge clk);
    req_valid[s] = 1'b0;
  endtask

  task automatic check_issue(input string tag);
    logic [SW-1:0] s; logic [KW-1:0] k; logic [AW-1:0] a;
    m_take(s, k, a);
    chk(issue_valid === 1'b1, "R9 issue present", issue_valid, 1);
    chk(issue_src == s && dram_addr == a, tag, {issue_src, dram_addr}, {s, a});
    chk({cs_n, ras_n, cas_n, we_n} == exp_pins(k), "R7 pin code", {cs_n, ras_n, cas_n, we_n}, exp_pins(k));
  endtask

  task automatic drain(input string tag);
    int n0 = m_n;
    @(negedge clk);
    issue_en = 1'b1;
    for (int j = 0; j < n0; j++) begin
      @(negedge clk);
      check_issue(tag);
    end
    @(negedge clk);
    chk(!issue_valid && {cs_n, ras_n, cas_n, we_n} == 4'b1111,
        "R8 empty queue deselect", {issue_valid, cs_n, ras_n, cas_n, we_n}, 5'b01111);
    issue_en = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111 && !issue_valid, "R1 reset pins",
        {issue_valid, cs_n, ras_n, cas_n, we_n}, 5'b01111);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == '0, "R1 no ready without valid", req_ready, 0);
  endtask

  task automatic t_round_robin;
    int exp_a[4] = '{0, 1, 2, 3};
    int exp_b[3] = '{1, 3, 1};
    @(negedge clk);
    req_valid = 4'b1111;
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < N; s++) set_req(s, 3'd2, 2'd1, AW'(16'h100 + c*16 + s));
      #1;
      chk(req_ready == (N'(1) << exp_a[c]), "R2 rotation all valid", req_ready, N'(1) << exp_a[c]);
      m_add(exp_a[c], 3'd2, 2'd1, AW'(16'h100 + c*16 + exp_a[c]));
      @(negedge clk);
    end
    req_valid = 4'b1010;
    for (int c = 0; c < 3; c++) begin
      for (int s = 0; s < N; s++) set_req(s, 3'd2, 2'd1, AW'(16'h200 + c*16 + s));
      #1;
      chk(req_ready == (N'(1) << exp_b[c]), "R2 rotation skips idle", req_ready, N'(1) << exp_b[c]);
      m_add(exp_b[c], 3'd2, 2'd1, AW'(16'h200 + c*16 + exp_b[c]));
      @(negedge clk);
    end
    req_valid = '0;
    drain("R5 R6 equal priority order");
  endtask

  task automatic t_priority;
    push_one(2, 3'd2, 2'd1, 16'hA001);
    push_one(0, 3'd3, 2'd1, 16'hA002);
    push_one(3, 3'd1, 2'd3, 16'hA003);
    push_one(1, 3'd4, 2'd0, 16'hA004);
    push_one(2, 3'd5, 2'd3, 16'hA005);
    push_one(0, 3'd2, 2'd1, 16'hA006);
    push_one(3, 3'd0, 2'd1, 16'hA007);
    push_one(1, 3'd7, 2'd2, 16'hA008);
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111 && !issue_valid, "R8 held while issue_en low",
        {issue_valid, cs_n, ras_n, cas_n, we_n}, 5'b01111);
    drain("R4 R5 R6 mixed order");
  endtask

  task automatic t_full;
    for (int i = 0; i < D; i++) push_one(0, 3'd2, PW'(i % 4), AW'(16'hB000 + i));
    @(negedge clk);
    set_req(1, 3'd3, 2'd2, 16'hC001);
    req_valid[1] = 1'b1;
    issue_en = 1'b1;
    #1;
    chk(req_ready == '0, "R3 full queue blocks ready", req_ready, 0);
    @(negedge clk);
    issue_en = 1'b0;
    check_issue("R4 pop from full queue");
    #1;
    chk(req_ready == 4'b0010, "R3 ready after slot freed", req_ready, 4'b0010);
    m_add(1, 3'd3, 2'd2, 16'hC001);
    @(negedge clk);
    req_valid[1] = 1'b0;
    drain("R9 all entries issue");
  endtask

  task automatic t_idle_enable;
    @(negedge clk);
    issue_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(!issue_valid && cs_n, "R8 enable on empty queue", {issue_valid, cs_n}, 2'b01);
    issue_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_round_robin();
    t_priority();
    t_full();
    t_idle_enable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule